// File: doc/BRIEF.md
# Serial HDLC Receive Framer with CRC-32 Check

This block sits behind a bit-level demodulator and turns a serial bit stream with HDLC framing into bytes. It finds the 0x7E flags that delimit frames, removes the zeros the sender inserted after runs of five ones, and packs the remaining body bits into bytes, least significant bit first. A serial CRC-32 runs over every body bit. When the closing flag arrives, an end-of-frame strobe reports whether the frame check passed.

A run of seven or more ones inside a frame is an abort. The frame ends at once and the receiver hunts for the next flag. A policy input chooses between two behaviours. In one, an aborted frame is closed with an end-of-frame strobe that carries an abort status. In the other, it is dropped and no status is ever reported. A configuration input tells the checker whether the sender sent the frame check sequence complemented, which is the default, or plain.

All body bytes are forwarded, the four check bytes included. A downstream consumer keeps the bytes of a frame until the end-of-frame strobe tells it the frame's fate. Bytes whose frame is never closed belong to a dropped frame.

Top module: `hdlc_crc_rx`

## Requirements
- R1: After reset, byte_vld, frame_sof, frame_eof, frame_crc_ok and frame_abort are all low.
- R2: A frame opens at a flag (bits 0,1,1,1,1,1,1,0 in line order) and closes at the next flag. Flag bits never appear in the data. frame_sof is high together with the first byte of a frame only. Two flags with nothing between them, whether they share a zero or not, produce no byte and no end-of-frame strobe.
- R3: A zero received right after five consecutive ones inside a frame is removed and contributes neither data nor CRC input.
- R4: Body bits are packed least significant bit first: the first destuffed bit of a byte is bit 0 of byte_data.
- R5: One clock after the last bit of a closing flag, frame_eof pulses for one cycle if the frame delivered at least one byte. frame_crc_ok is high in that cycle only when the frame holds a whole number of bytes, at least four of them, and the CRC-32 (polynomial 0x04C11DB7, bit-reflected, register preset to all ones at frame start) over all body bits, check bytes included, leaves the expected residue.
- R6: With cfg_fcs_plain low, the check expects the sender's check bytes to be the complemented CRC, sent LSB first. With it high, it expects the uncomplemented CRC. A frame built for the other setting fails.
- R7: A closed frame with one to three bytes reports frame_crc_ok low.
- R8: Seven consecutive ones inside an open frame abort it. The six ones and the one bit before them are never delivered, and neither is an incomplete byte. Bits that follow are ignored until the next flag, which opens a new frame.
- R9: With cfg_keep_abort high, an abort in a frame that delivered at least one byte gives a frame_eof pulse one clock after the seventh one, with frame_abort high and frame_crc_ok low.
- R10: With cfg_keep_abort low, an aborted frame produces no frame_eof and frame_abort never rises. The following frame is received normally.
- R11: A cycle with bit_vld low has no effect: bit_in is ignored and no output strobe appears in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Received line bit |
| bit_vld | input | 1 | bit_in carries a bit this cycle |
| cfg_fcs_plain | input | 1 | 1: check bytes sent uncomplemented; 0: complemented |
| cfg_keep_abort | input | 1 | 1: report aborted frames; 0: drop them silently |
| byte_vld | output | 1 | byte_data holds a body byte |
| byte_data | output | 8 | Destuffed body byte, first bit in bit 0 |
| frame_sof | output | 1 | First byte of a frame (with byte_vld) |
| frame_eof | output | 1 | Frame closed; status valid this cycle |
| frame_crc_ok | output | 1 | Frame check passed (with frame_eof) |
| frame_abort | output | 1 | Frame ended by abort (with frame_eof) |

## Verification
Random-length frames with random contents are sent under both check settings. Some carry a correct check sequence, some a corrupted byte, and some a sequence built for the opposite setting. This separates the CRC arithmetic, the residue selection and the bit order. A directed frame full of 0xFF and 0x7E bytes forces many stuffed zeros, which shows whether destuffing runs before both the packer and the CRC. Short frames, back-to-back flags, and aborts under each policy with junk bytes after the abort run exercise the framing boundaries. Random idle cycles with garbage on bit_in check that only qualified bits count.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

  // mirror a polynomial so the register can shift toward bit 0
  function automatic logic [CRC_W-1:0] mirror(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  // one serial CRC step, line bit enters at the low end
  function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? mirror(CRC_POLY) : '0);
  endfunction

  // register value left after a frame whose check bytes are correct.
  // plain check bytes cancel the register to zero; complemented ones
  // leave the effect of 32 one-bits fed into an empty register.
  function automatic logic [CRC_W-1:0] crc_residue(input logic plain);
    logic [CRC_W-1:0] r;
    r = '0;
    if (!plain)
      for (int i = 0; i < CRC_W; i++) r = crc_bit(r, 1'b1);
    return r;
  endfunction
endpackage

// File: rtl/hdlc_bit_class.sv
module hdlc_bit_class #(
  parameter int RUN_FLAG = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic ev_data,
  output logic ev_stuff,
  output logic ev_flag,
  output logic ev_abort
);
  localparam int OW = $clog2(RUN_FLAG + 2);
  localparam logic [OW-1:0] RUN_STUFF = OW'(RUN_FLAG - 1);
  localparam logic [OW-1:0] RUN_TOP   = OW'(RUN_FLAG);
  localparam logic [OW-1:0] RUN_SAT   = OW'(RUN_FLAG + 1);

  logic [OW-1:0] ones_q;

  always_comb begin
    ev_data  = 1'b0;
    ev_stuff = 1'b0;
    ev_flag  = 1'b0;
    ev_abort = 1'b0;
    if (bit_vld) begin
      if (bit_in) begin
        if (ones_q == RUN_TOP)     ev_abort = 1'b1;
        else if (ones_q < RUN_TOP) ev_data  = 1'b1;
      end else begin
        if (ones_q == RUN_STUFF)   ev_stuff = 1'b1;
        else if (ones_q == RUN_TOP) ev_flag = 1'b1;
        else if (ones_q < RUN_TOP) ev_data  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ones_q <= '0;
    else if (bit_vld && !bit_in) ones_q <= '0;
    else if (bit_vld && ones_q != RUN_SAT) ones_q <= ones_q + 1'b1;
  end
endmodule

// File: rtl/hdlc_hold_line.sv
module hdlc_hold_line #(
  parameter int DEPTH = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic bit_in,
  output logic out_vld,
  output logic out_bit
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DEPTH-1:0] q_q;
  logic [CW-1:0]    cnt_q;

  assign out_vld = push && (cnt_q == FULL);
  assign out_bit = q_q[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (push) begin
      q_q   <= {q_q[DEPTH-2:0], bit_in};
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_byte_packer.sv
module hdlc_byte_packer
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int FCS_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              bit_in,
  output logic              done,
  output logic [BYTE_W-1:0] byte_val,
  output logic [CRC_W-1:0]  crc_q,
  output logic              whole,
  output logic              enough
);
  localparam int CW = $clog2(BYTE_W);
  localparam int NW = $clog2(FCS_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);
  localparam logic [NW-1:0] NMAX = NW'(FCS_BYTES);

  logic [BYTE_W-2:0] sh_q;
  logic [CW-1:0]     bc_q;
  logic [NW-1:0]     nb_q;

  assign done     = take && (bc_q == LAST);
  assign byte_val = {bit_in, sh_q};
  assign whole    = (bc_q == '0);
  assign enough   = (nb_q == NMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bc_q  <= '0;
      nb_q  <= '0;
      crc_q <= '1;
    end else if (clr) begin
      bc_q  <= '0;
      nb_q  <= '0;
      crc_q <= '1;
    end else if (take) begin
      sh_q  <= {bit_in, sh_q[BYTE_W-2:1]};
      bc_q  <= done ? '0 : bc_q + 1'b1;
      crc_q <= crc_bit(crc_q, bit_in);
      if (done && nb_q != NMAX) nb_q <= nb_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_crc_rx.sv
module hdlc_crc_rx
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int FCS_BYTES = 4,
  parameter int RUN_FLAG  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_vld,
  input  logic              cfg_fcs_plain,
  input  logic              cfg_keep_abort,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic              frame_sof,
  output logic              frame_eof,
  output logic              frame_crc_ok,
  output logic              frame_abort
);
  // a flag is a zero, RUN_FLAG ones and a zero; everything the flag
  // pushed as tentative data fits in this many held bits
  localparam int HOLD = RUN_FLAG + 1;

  logic ev_data, ev_stuff, ev_flag, ev_abort;
  logic open_q, started_q;
  logic push, cut;
  logic hl_vld, hl_bit;
  logic pk_done, pk_whole, pk_enough;
  logic [BYTE_W-1:0] pk_byte;
  logic [CRC_W-1:0]  pk_crc;
  logic eof_fire, fcs_match;

  hdlc_bit_class #(.RUN_FLAG(RUN_FLAG)) u_class (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .ev_data(ev_data), .ev_stuff(ev_stuff), .ev_flag(ev_flag), .ev_abort(ev_abort)
  );

  assign push = ev_data && open_q;
  assign cut  = ev_flag || ev_abort;

  hdlc_hold_line #(.DEPTH(HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(cut), .push(push), .bit_in(bit_in),
    .out_vld(hl_vld), .out_bit(hl_bit)
  );

  hdlc_byte_packer #(.BYTE_W(BYTE_W), .FCS_BYTES(FCS_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(cut), .take(hl_vld), .bit_in(hl_bit),
    .done(pk_done), .byte_val(pk_byte), .crc_q(pk_crc),
    .whole(pk_whole), .enough(pk_enough)
  );

  assign fcs_match = pk_whole && pk_enough && (pk_crc == crc_residue(cfg_fcs_plain));
  assign eof_fire  = started_q && (ev_flag || (ev_abort && cfg_keep_abort));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q       <= 1'b0;
      started_q    <= 1'b0;
      byte_vld     <= 1'b0;
      byte_data    <= '0;
      frame_sof    <= 1'b0;
      frame_eof    <= 1'b0;
      frame_crc_ok <= 1'b0;
      frame_abort  <= 1'b0;
    end else begin
      byte_vld     <= pk_done;
      frame_sof    <= pk_done && !started_q;
      frame_eof    <= eof_fire;
      frame_crc_ok <= eof_fire && ev_flag && fcs_match;
      frame_abort  <= eof_fire && ev_abort;
      if (pk_done) byte_data <= pk_byte;
      if (ev_flag)       open_q <= 1'b1;
      else if (ev_abort) open_q <= 1'b0;
      if (cut)          started_q <= 1'b0;
      else if (pk_done) started_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_crc_rx_chk.sv
module hdlc_crc_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic cfg_keep_abort,
  input logic byte_vld,
  input logic frame_sof,
  input logic frame_eof,
  input logic frame_crc_ok,
  input logic frame_abort,
  input logic ev_data,
  input logic ev_stuff,
  input logic ev_flag,
  input logic ev_abort
);
  p_sof_with_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sof |-> byte_vld);
  p_one_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_data, ev_stuff, ev_flag, ev_abort}));
  p_eof_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_eof |-> !byte_vld);
  p_ok_needs_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_crc_ok |-> frame_eof);
  p_abort_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> (frame_eof && !frame_crc_ok));
  p_drop_policy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> $past(cfg_keep_abort));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> (!byte_vld && !frame_eof));
  p_event_needs_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data || ev_stuff || ev_flag || ev_abort) |-> bit_vld);
endmodule

bind hdlc_crc_rx hdlc_crc_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .cfg_keep_abort(cfg_keep_abort),
  .byte_vld(byte_vld), .frame_sof(frame_sof), .frame_eof(frame_eof),
  .frame_crc_ok(frame_crc_ok), .frame_abort(frame_abort),
  .ev_data(ev_data), .ev_stuff(ev_stuff), .ev_flag(ev_flag), .ev_abort(ev_abort)
);

// File: tb/hdlc_crc_rx_test.sv
module hdlc_crc_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0, bit_vld = 1'b0;
  logic cfg_fcs_plain = 1'b0, cfg_keep_abort = 1'b0;
  logic byte_vld, frame_sof, frame_eof, frame_crc_ok, frame_abort;
  logic [7:0] byte_data;

  always #10 clk = ~clk;

  hdlc_crc_rx uut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .cfg_fcs_plain(cfg_fcs_plain), .cfg_keep_abort(cfg_keep_abort),
    .byte_vld(byte_vld), .byte_data(byte_data), .frame_sof(frame_sof),
    .frame_eof(frame_eof), .frame_crc_ok(frame_crc_ok), .frame_abort(frame_abort)
  );

  int total = 0, bad = 0, cycles = 0, tx_ones = 0;
  int got_n, sof_n, sof_misplaced, eof_n, idle_err;
  logic last_ok, last_abort;
  logic [7:0] got [0:63];
  logic [7:0] exp [0:63];
  int exp_n;

  task automatic chk(input logic cond, input string tag, input longint act, input longint expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic clear_log();
    got_n = 0; sof_n = 0; sof_misplaced = 0; eof_n = 0; idle_err = 0;
    last_ok = 1'b0; last_abort = 1'b0;
  endtask

  task automatic observe(input logic was_valid);
    if (byte_vld) begin
      if (!was_valid) idle_err++;
      if (frame_sof) begin
        sof_n++;
        if (got_n != 0) sof_misplaced++;
      end
      if (got_n < 64) got[got_n] = byte_data;
      got_n++;
    end
    if (frame_eof) begin
      if (!was_valid) idle_err++;
      eof_n++;
      last_ok = frame_crc_ok;
      last_abort = frame_abort;
    end
  endtask

  task automatic step(input logic v, input logic b);
    bit_vld = v; bit_in = b;
    @(posedge clk);
    @(negedge clk);
    bit_vld = 1'b0;
    observe(v);
  endtask

  // random idle cycles carry junk on bit_in (R11)
  task automatic line_bit(input logic b);
    if ($urandom % 4 == 0) step(1'b0, 1'($urandom));
    step(1'b1, b);
  endtask

  task automatic send_flag();
    line_bit(1'b0);
    for (int i = 0; i < 6; i++) line_bit(1'b1);
    line_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      line_bit(v[i]);
      if (v[i]) begin
        tx_ones++;
        if (tx_ones == 5) begin
          line_bit(1'b0);
          tx_ones = 0;
        end
      end else tx_ones = 0;
    end
  endtask

  // bytewise reflected CRC-32 of exp[0:n-1]
  function automatic logic [31:0] fcs_of(input int n, input logic plain);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ {24'h0, exp[k]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return plain ? c : ~c;
  endfunction

  // appends the check bytes to exp[0:n-1], built for setting plain
  task automatic add_fcs(input int n, input logic plain);
    logic [31:0] f;
    f = fcs_of(n, plain);
    for (int k = 0; k < 4; k++) exp[n+k] = f[8*k +: 8];
    exp_n = n + 4;
  endtask

  task automatic send_exp_frame();
    clear_log();
    send_flag();
    for (int k = 0; k < exp_n; k++) send_byte(exp[k]);
    send_flag();
  endtask

  function automatic int mism(input int n);
    int m = 0;
    for (int k = 0; k < n; k++) if (got[k] !== exp[k]) m++;
    return m;
  endfunction

  task automatic check_closed(input string tag, input logic exp_ok);
    chk(got_n == exp_n, {tag, " byte count"}, got_n, exp_n);
    chk(mism(exp_n) == 0, {tag, " R4 byte values LSB first"}, mism(exp_n), 0);
    chk(sof_n == 1 && sof_misplaced == 0, {tag, " R2 single sof on first byte"}, sof_n, 1);
    chk(eof_n == 1, {tag, " R5 eof count"}, eof_n, 1);
    chk(last_ok == exp_ok, {tag, " R5 crc status"}, last_ok, exp_ok);
    chk(last_abort == 1'b0, {tag, " R9 no abort on clean close"}, last_abort, 0);
    chk(idle_err == 0, {tag, " R11 no output after idle cycle"}, idle_err, 0);
  endtask

  task automatic abort_case(input logic keep, input int n);
    clear_log();
    cfg_keep_abort = keep;
    send_flag();
    exp_n = n;
    for (int k = 0; k < n; k++) begin
      exp[k] = 8'($urandom);
      if (k == n - 1) exp[k][7] = 1'b0;
      send_byte(exp[k]);
    end
    for (int i = 0; i < 8; i++) line_bit(1'b1);
    tx_ones = 0;
    for (int k = 0; k < 3; k++) send_byte(8'($urandom));
    send_flag();
    send_flag();
    // 8n bits plus six ones pushed, last seven withheld
    chk(got_n == (8*n - 1) / 8, "R8 bytes before abort", got_n, (8*n - 1) / 8);
    chk(mism(got_n) == 0, "R8 delivered bytes intact", mism(got_n), 0);
    if (keep) begin
      chk(eof_n == 1 && last_abort == 1'b1, "R9 abort reported", eof_n, 1);
      chk(last_ok == 1'b0, "R9 abort crc low", last_ok, 0);
    end else begin
      chk(eof_n == 0, "R10 aborted frame dropped", eof_n, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(byte_vld == 0 && frame_sof == 0 && frame_eof == 0, "R1 strobes low in reset",
        {byte_vld, frame_sof, frame_eof}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_crc_ok == 0 && frame_abort == 0, "R1 status low after reset",
        {frame_crc_ok, frame_abort}, 0);

    // back-to-back flags, separate and with a shared zero
    clear_log();
    send_flag(); send_flag(); send_flag();
    for (int i = 0; i < 6; i++) line_bit(1'b1);
    line_bit(1'b0);
    chk(got_n == 0 && eof_n == 0, "R2 empty frames silent", got_n + eof_n, 0);

    // stuffing-heavy directed frame
    cfg_fcs_plain = 1'b0;
    exp[0] = 8'hFF; exp[1] = 8'hFF; exp[2] = 8'h7E; exp[3] = 8'h3F; exp[4] = 8'hF8;
    add_fcs(5, 1'b0);
    send_exp_frame();
    check_closed("R3 stuffed frame", 1'b1);

    // plain setting, good frame
    cfg_fcs_plain = 1'b1;
    exp[0] = 8'h01; exp[1] = 8'h80; exp[2] = 8'hA5;
    add_fcs(3, 1'b1);
    send_exp_frame();
    check_closed("R6 plain good", 1'b1);

    // check bytes built for the other setting
    cfg_fcs_plain = 1'b0;
    add_fcs(3, 1'b1);
    send_exp_frame();
    check_closed("R6 setting mismatch", 1'b0);
    cfg_fcs_plain = 1'b1;
    add_fcs(3, 1'b0);
    send_exp_frame();
    check_closed("R6 setting mismatch plain", 1'b0);

    // short frames
    for (int n = 1; n <= 3; n++) begin
      cfg_fcs_plain = 1'b1;
      for (int k = 0; k < n; k++) exp[k] = 8'h00;
      exp_n = n;
      send_exp_frame();
      check_closed("R7 short frame", 1'b0);
    end

    // random frames, random setting, some corrupted
    for (int t = 0; t < 24; t++) begin
      int n;
      logic plain, spoil;
      n = 1 + int'($urandom % 12);
      plain = 1'($urandom);
      spoil = ($urandom % 3 == 0);
      cfg_fcs_plain = plain;
      for (int k = 0; k < n; k++) exp[k] = 8'($urandom);
      add_fcs(n, plain);
      if (spoil) exp[$urandom % exp_n] ^= 8'(1 + $urandom % 255);
      send_exp_frame();
      check_closed("R5 random frame", !spoil);
    end

    // aborts under both policies, each followed by a normal frame
    abort_case(1'b1, 3);
    abort_case(1'b0, 5);
    cfg_fcs_plain = 1'b0;
    exp[0] = 8'h55; exp[1] = 8'hC3;
    add_fcs(2, 1'b0);
    send_exp_frame();
    check_closed("R10 frame after dropped abort", 1'b1);
    abort_case(1'b1, 2);
    abort_case(1'b0, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule